// File: doc/BRIEF.md
# Streaming Payload CRC-16 Generator and Footer Checker

This block computes the 16-bit checksum that closes a serial-link long packet. The payload is streamed into it one byte per clock, with a start strobe that carries the payload byte count and a valid strobe that marks each payload byte. The count may be anything from 0 to 65535. A done pulse flags the point at which the checksum output is final.

Once the payload is complete, the same byte stream delivers the two received footer bytes, low byte first. The block compares the received footer with its own result and raises a mismatch flag together with a check pulse. A received footer of 0000h means the sender did not compute a checksum, and the block always accepts it.

The checksum is a reflected CRC-16 that is seeded with all ones and absorbs each byte least significant bit first. All eight bit steps are unrolled, so the block absorbs one full byte per cycle and never stalls.

Top module: `payload_crc16`

## Requirements
- R1: After reset `crcOut` is FFFFh, and `done`, `checkDone` and `footerBad` are 0.
- R2: A `start` seeds the checksum register with FFFFh. With `wordCount` = 0, `done` is high in the cycle after `start` and `crcOut` is FFFFh.
- R3: For each payload byte, the byte is XORed into bits 7:0 of the register. The register then shifts right eight times, and after each shift it is XORed with 8408h whenever the bit shifted out was 1.
- R4: `done` is a one-cycle pulse in the cycle after the clock edge that takes the `wordCount`-th payload byte. It does not assert for any earlier byte.
- R5: Cycles with `byteValid` low are ignored, whatever the value on `byteData`.
- R6: The two bytes with `byteValid` high that follow the payload are the received footer, low byte first. `checkDone` pulses for one cycle after the second byte. In that cycle `footerBad` is 1 exactly when the footer is non-zero and differs from `crcOut`.
- R7: A received footer of 0000h never raises `footerBad`.
- R8: A `start` in the middle of a packet abandons that packet and begins a new one.
- R9: After `done`, `crcOut` holds its value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a packet and samples `wordCount` |
| wordCount | input | COUNT_W | Payload length in bytes |
| byteValid | input | 1 | Marks a valid byte on `byteData` |
| byteData | input | 8 | Payload byte, then the two footer bytes |
| crcOut | output | 16 | Running, then final, checksum |
| done | output | 1 | Checksum is final (one-cycle pulse) |
| checkDone | output | 1 | Footer comparison result is valid (pulse) |
| footerBad | output | 1 | Received non-zero footer disagrees |

## Verification
Every result comes one register stage after the edge that takes its cause. `done` and the final `crcOut` appear one cycle after the last payload byte, or one cycle after `start` for an empty payload. `checkDone` and `footerBad` appear one cycle after the second footer byte. The bench drives its inputs on falling edges and reads outputs on the next falling edge. It therefore checks `done` after every byte, expecting it high only after the last one. It checks the footer verdict exactly one cycle after the high footer byte, and one cycle later it checks that the pulse has cleared and that `crcOut` is unchanged.

// File: rtl/payload_crc16_pkg.sv
package payload_crc16_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;

  typedef struct packed {
    logic clear;
    logic absorb;
    logic capLo;
    logic capHi;
  } crcStrobes_t;
endpackage

// File: rtl/payload_crc16_ctrl.sv
module payload_crc16_ctrl
  import payload_crc16_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COUNT_W-1:0] wordCount,
  input  logic               byteValid,
  output crcStrobes_t        strobes,
  output logic               done
);
  typedef enum logic [1:0] {S_IDLE, S_PAYLOAD, S_FOOT_LO, S_FOOT_HI} ctrlState_t;

  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  ctrlState_t state;
  logic [COUNT_W-1:0] remaining;

  always_comb begin
    strobes.clear  = start;
    strobes.absorb = !start && (state == S_PAYLOAD) && byteValid;
    strobes.capLo  = !start && (state == S_FOOT_LO) && byteValid;
    strobes.capHi  = !start && (state == S_FOOT_HI) && byteValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remaining <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        remaining <= wordCount;
        if (wordCount == '0) begin
          state <= S_FOOT_LO;
          done  <= 1'b1;
        end else begin
          state <= S_PAYLOAD;
        end
      end else begin
        unique case (state)
          S_PAYLOAD: if (byteValid) begin
            remaining <= remaining - ONE;
            if (remaining == ONE) begin
              state <= S_FOOT_LO;
              done  <= 1'b1;
            end
          end
          S_FOOT_LO: if (byteValid) state <= S_FOOT_HI;
          S_FOOT_HI: if (byteValid) state <= S_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R4: done lasts one cycle unless an empty packet restarts it
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> !done);

  // R5: an idle payload cycle leaves the byte counter untouched
  a_r5_gap_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PAYLOAD) && !byteValid && !start |=> $stable(remaining));

  // R8: a start always seeds and never absorbs in the same cycle
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |-> strobes.clear && !strobes.absorb && !strobes.capHi);
endmodule

// File: rtl/payload_crc16_datapath.sv
module payload_crc16_datapath
  import payload_crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h8408,
  parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobes_t       strobes,
  input  logic [BYTE_W-1:0] byteData,
  output logic [CRC_W-1:0]  crcOut,
  output logic              checkDone,
  output logic              footerBad
);
  logic [CRC_W-1:0]  crcReg;
  logic [BYTE_W-1:0] footLo;
  logic [CRC_W-1:0]  footerWord;
  logic [CRC_W-1:0]  rxFooter;
  logic [CRC_W-1:0]  crcNext;

  function automatic logic [CRC_W-1:0] absorbByte(input logic [CRC_W-1:0] acc,
                                                   input logic [BYTE_W-1:0] b);
    logic [CRC_W-1:0] r;
    r = acc ^ {{(CRC_W-BYTE_W){1'b0}}, b};
    for (int k = 0; k < BYTE_W; k++) begin
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    end
    return r;
  endfunction

  assign crcNext  = absorbByte(crcReg, byteData);
  assign rxFooter = {byteData, footLo};
  assign crcOut   = crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg     <= SEED;
      footLo     <= '0;
      footerWord <= '0;
      checkDone  <= 1'b0;
      footerBad  <= 1'b0;
    end else begin
      checkDone <= 1'b0;
      footerBad <= 1'b0;
      if (strobes.clear)       crcReg <= SEED;
      else if (strobes.absorb) crcReg <= crcNext;
      if (strobes.capLo) footLo <= byteData;
      if (strobes.capHi) begin
        footerWord <= rxFooter;
        checkDone  <= 1'b1;
        footerBad  <= (rxFooter != '0) && (rxFooter != crcReg);
      end
    end
  end

  // R2: the register holds the seed right after a start
  a_r2_seed: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> crcReg == SEED);

  // R6: a mismatch is only ever reported with its check pulse
  a_r6_bad_with_check: assert property (@(posedge clk) disable iff (!rstN)
    footerBad |-> checkDone);

  // R6: the check pulse lasts a single cycle
  a_r6_check_pulse: assert property (@(posedge clk) disable iff (!rstN)
    checkDone |=> !checkDone);

  // R7: an all-zero footer is always accepted
  a_r7_zero_ok: assert property (@(posedge clk) disable iff (!rstN)
    checkDone && (footerWord == '0) |-> !footerBad);

  // R9: without a seed or absorb strobe the checksum stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clear && !strobes.absorb |=> $stable(crcReg));
endmodule

// File: rtl/payload_crc16.sv
module payload_crc16
  import payload_crc16_pkg::*;
#(
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COUNT_W-1:0] wordCount,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  output logic [15:0]        crcOut,
  output logic               done,
  output logic               checkDone,
  output logic               footerBad
);
  crcStrobes_t strobes;

  payload_crc16_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .byteValid(byteValid), .strobes(strobes), .done(done)
  );

  payload_crc16_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .crcOut(crcOut), .checkDone(checkDone), .footerBad(footerBad)
  );
endmodule

// File: tb/sim_payload_crc16.sv
`timescale 1ns/1ps
module sim_payload_crc16;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] wordCount = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic [15:0] crcOut;
  logic        done, checkDone, footerBad;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] pay [0:299];

  always #2.5 clk = ~clk;

  payload_crc16 u0 (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .byteValid(byteValid), .byteData(byteData), .crcOut(crcOut),
    .done(done), .checkDone(checkDone), .footerBad(footerBad)
  );

  function automatic logic [15:0] refCrc(input int len);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      c ^= {8'h00, pay[i]};
      for (int b = 0; b < 8; b++) begin
        if (c[0]) c = (c >> 1) ^ 16'h8408;
        else      c = c >> 1;
      end
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // fmode: 0 correct footer, 1 zero footer, 2 wrong footer
  task automatic sendPacket(input int len, input int gapPct, input int fmode);
    logic [15:0] exp;
    logic [15:0] foot;
    exp = refCrc(len);
    start = 1'b1; wordCount = 16'(len); byteValid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (int'($urandom_range(99)) < gapPct) begin
        byteValid = 1'b0; byteData = 8'($urandom);
        @(negedge clk);
        check("R5 no done in gap", done, 1'b0);
      end
      byteValid = 1'b1; byteData = pay[i];
      @(negedge clk);
      check("R4 done timing", done, (i == len - 1));
      if (i == len - 1) check("R3 checksum", crcOut, exp);
    end
    if (len == 0) begin
      check("R2 empty done", done, 1'b1);
      check("R2 empty checksum", crcOut, 16'hFFFF);
    end
    byteValid = 1'b0; byteData = 8'($urandom);
    @(negedge clk);
    check("R4 done pulse ends", done, 1'b0);
    check("R9 checksum held", crcOut, exp);
    foot = (fmode == 0) ? exp : (fmode == 1) ? 16'h0000 : (exp ^ 16'h0100);
    byteValid = 1'b1; byteData = foot[7:0];
    @(negedge clk);
    check("R6 no early check", checkDone, 1'b0);
    byteData = foot[15:8];
    @(negedge clk);
    byteValid = 1'b0;
    check("R6 checkDone", checkDone, 1'b1);
    if (fmode == 1) check("R7 zero footer accepted", footerBad, 1'b0);
    else            check("R6 footer verdict", footerBad, (fmode == 2));
    @(negedge clk);
    check("R6 check pulse ends", checkDone, 1'b0);
    check("R9 checksum still held", crcOut, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish();
  end

  initial begin
    int dummy;
    dummy = $urandom(32'h5EED_0C1C);
    for (int i = 0; i < 300; i++) pay[i] = 8'($urandom);
    @(negedge clk);
    check("R1 reset checksum", crcOut, 16'hFFFF);
    check("R1 reset done", done, 1'b0);
    check("R1 reset checkDone", checkDone, 1'b0);
    check("R1 reset footerBad", footerBad, 1'b0);
    rstN = 1'b1;
    @(negedge clk);

    sendPacket(0, 0, 0);
    sendPacket(0, 0, 2);
    sendPacket(1, 0, 0);
    sendPacket(2, 50, 1);
    pay[0] = 8'h00; pay[1] = 8'hFF; pay[2] = 8'h80; pay[3] = 8'h01;
    sendPacket(4, 0, 2);
    sendPacket(300, 30, 0);

    // R8: abandon a packet midway and start over
    start = 1'b1; wordCount = 16'd10;
    @(negedge clk);
    start = 1'b0; byteValid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      byteData = 8'($urandom);
      @(negedge clk);
      check("R8 partial has no done", done, 1'b0);
    end
    byteValid = 1'b0;
    sendPacket(5, 20, 0);

    for (int n = 0; n < 25; n++) begin
      for (int i = 0; i < 300; i++) pay[i] = 8'($urandom);
      sendPacket(int'($urandom_range(60)), int'($urandom_range(60)),
                 int'($urandom_range(2)));
    end
    finish();
  end
endmodule